// File: doc/BRIEF.md
# Scanline Interrupt and Multiplier Register File

This block is a small register file that sits in the register window of a cartridge bank controller. The CPU programs an 8-bit target scanline and an interrupt enable. The video side reports a scanline match with a one-cycle pulse on `line_hit_i`. The pulse latches a pending flag in bit 7 of a status byte. The interrupt line stays high while the pending flag and the enable are both set. An ordinary CPU read of the status byte acknowledges the interrupt. A read qualified as a debug access returns the same byte and acknowledges nothing.

The same window also holds an unsigned multiplier of two operand bytes. The 16-bit product is read back through two byte-wide registers. A read of any other window offset returns open-bus data: the last byte seen on the data bus, whether the CPU wrote it or the block returned it on a read.

Top module: `irq_mul_regs`

## Requirements
- R1: After reset, `irq_o` is 0, `cmp_o` is 0x00, the status byte reads 0x00 and both product bytes read 0x00.
- R2: A write to offset 0x203 loads the data byte into the target scanline. `cmp_o` shows the new value from the next cycle on.
- R3: A write to offset 0x204 takes the enable from data bit 7 and ignores the other bits. Writing 0x7F leaves the enable cleared.
- R4: A pulse on `line_hit_i` sets status bit 7. A read of offset 0x204 then returns 0x80, because all other status bits are 0.
- R5: `irq_o` is 1 exactly when the enable and status bit 7 are both 1. Clearing the enable drops `irq_o` and leaves status bit 7 set.
- R6: A non-debug read of offset 0x204 returns the full status byte, then clears status bit 7 and drops `irq_o` in the following cycle.
- R7: A read with `dbg_i` high returns the same data as a normal read. It leaves status bit 7, `irq_o` and the open-bus byte unchanged.
- R8: Writes to offsets 0x205 and 0x206 load the two unsigned operands. Reads of 0x205 and 0x206 return the low and high bytes of their product, valid from the cycle after the write.
- R9: A read of any other offset, 0x203 included, returns the last byte written by the CPU or returned by a non-debug read.
- R10: When a scanline-match pulse and a clearing status read fall in the same cycle, the read returns the old status and status bit 7 ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Offset within the register window |
| wdata_i | input | DATA_W | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| dbg_i | input | 1 | Qualifies a read as free of side effects |
| rdata_o | output | DATA_W | Read data, combinational while `rd_i` is high |
| line_hit_i | input | 1 | Scanline-match pulse from the video side |
| cmp_o | output | DATA_W | Programmed target scanline |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is a match pulse that lands in the same cycle as an acknowledging status read. The bench drives both strobes on one falling edge so that they meet at one rising edge, then checks that the interrupt is still raised and the flag still set. The debug-read path is also hard to see, because a debug read changes nothing. After each debug read the bench looks at `irq_o`, re-reads the status with another debug read, and reads an unmapped offset to show that the open-bus byte has not moved. The multiplier is swept over every first operand paired with sixteen spread second operands, and the product is computed in the bench.

// File: rtl/irq_mul_pkg.sv
package irq_mul_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP,
    SEL_STAT,
    SEL_OPA,
    SEL_OPB
  } reg_sel_e;
endpackage

// File: rtl/irq_mul_addr_dec.sv
module irq_mul_addr_dec
  import irq_mul_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CMP_OFF  = ADDR_W'('h203),
  parameter logic [ADDR_W-1:0] STAT_OFF = ADDR_W'('h204),
  parameter logic [ADDR_W-1:0] OPA_OFF  = ADDR_W'('h205),
  parameter logic [ADDR_W-1:0] OPB_OFF  = ADDR_W'('h206)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    unique case (addr_i)
      CMP_OFF:  sel_o = SEL_CMP;
      STAT_OFF: sel_o = SEL_STAT;
      OPA_OFF:  sel_o = SEL_OPA;
      OPB_OFF:  sel_o = SEL_OPB;
      default:  sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irq_mul_irq.sv
module irq_mul_irq #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_wr_i,
  input  logic              en_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  input  logic              hit_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              en_o,
  output logic              pend_o,
  output logic              irq_o
);
  localparam int unsigned TOP = DATA_W - 1;

  logic [DATA_W-1:0] cmp_q;
  logic              en_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_wr_i) cmp_q <= wdata_i;
      if (en_wr_i)  en_q  <= wdata_i[TOP];
      // a new match wins over an acknowledge in the same cycle
      if (hit_i)      pend_q <= 1'b1;
      else if (ack_i) pend_q <= 1'b0;
    end
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = en_q & pend_q;
endmodule

// File: rtl/irq_mul_mult.sv
module irq_mul_mult #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PROD_W-1:0] prod_o
);
  logic [DATA_W-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (wr_a_i) a_q <= wdata_i;
      if (wr_b_i) b_q <= wdata_i;
    end
  end

  assign prod_o = PROD_W'(a_q) * PROD_W'(b_q);
endmodule

// File: rtl/irq_mul_regs.sv
module irq_mul_regs
  import irq_mul_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMP_OFF  = ADDR_W'('h203),
  parameter logic [ADDR_W-1:0] STAT_OFF = ADDR_W'('h204),
  parameter logic [ADDR_W-1:0] OPA_OFF  = ADDR_W'('h205),
  parameter logic [ADDR_W-1:0] OPB_OFF  = ADDR_W'('h206)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              dbg_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              line_hit_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              irq_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  reg_sel_e          sel;
  logic              en_w, pend_w, ack;
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] bus_q;

  irq_mul_addr_dec #(
    .ADDR_W(ADDR_W), .CMP_OFF(CMP_OFF), .STAT_OFF(STAT_OFF),
    .OPA_OFF(OPA_OFF), .OPB_OFF(OPB_OFF)
  ) u_dec (
    .addr_i(addr_i),
    .sel_o (sel)
  );

  assign ack = rd_i && !dbg_i && (sel == SEL_STAT);

  irq_mul_irq #(.DATA_W(DATA_W)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmp_wr_i(wr_i && sel == SEL_CMP),
    .en_wr_i (wr_i && sel == SEL_STAT),
    .wdata_i (wdata_i),
    .ack_i   (ack),
    .hit_i   (line_hit_i),
    .cmp_o   (cmp_o),
    .en_o    (en_w),
    .pend_o  (pend_w),
    .irq_o   (irq_o)
  );

  irq_mul_mult #(.DATA_W(DATA_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_a_i (wr_i && sel == SEL_OPA),
    .wr_b_i (wr_i && sel == SEL_OPB),
    .wdata_i(wdata_i),
    .prod_o (prod)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = {pend_w, {(DATA_W-1){1'b0}}};
      SEL_OPA:  rdata_o = prod[DATA_W-1:0];
      SEL_OPB:  rdata_o = prod[PROD_W-1:DATA_W];
      default:  rdata_o = bus_q;
    endcase
  end

  // open-bus byte: last data that crossed the bus, debug reads excluded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                bus_q <= '0;
    else if (wr_i)              bus_q <= wdata_i;
    else if (rd_i && !dbg_i)    bus_q <= rdata_o;
  end
endmodule

// File: rtl/irq_mul_regs_chk.sv
module irq_mul_regs_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] CMP_OFF  = ADDR_W'('h203),
  parameter logic [ADDR_W-1:0] STAT_OFF = ADDR_W'('h204)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              dbg_i,
  input logic              line_hit_i,
  input logic [DATA_W-1:0] cmp_o,
  input logic              irq_o,
  input logic              en_w,
  input logic              pend_w
);
  assert_cmp_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == CMP_OFF) |=> cmp_o == $past(wdata_i));

  assert_en_bit7_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == STAT_OFF) |=> en_w == $past(wdata_i[DATA_W-1]));

  assert_hit_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_hit_i |=> pend_w);

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_w && pend_w));

  assert_ack_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !dbg_i && addr_i == STAT_OFF && !line_hit_i) |=> !irq_o && !pend_w);

  assert_dbg_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && dbg_i && !wr_i && !line_hit_i) |=> $stable(pend_w) && $stable(irq_o));

  assert_hit_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !dbg_i && addr_i == STAT_OFF && line_hit_i) |=> pend_w);
endmodule

bind irq_mul_regs irq_mul_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_OFF(CMP_OFF), .STAT_OFF(STAT_OFF)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .wr_i      (wr_i),
  .rd_i      (rd_i),
  .dbg_i     (dbg_i),
  .line_hit_i(line_hit_i),
  .cmp_o     (cmp_o),
  .irq_o     (irq_o),
  .en_w      (en_w),
  .pend_w    (pend_w)
);

// File: tb/tb_irq_mul_regs.sv
`timescale 1ns/1ps
module tb_irq_mul_regs;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] A_CMP  = 12'h203;
  localparam logic [AW-1:0] A_STAT = 12'h204;
  localparam logic [AW-1:0] A_PLO  = 12'h205;
  localparam logic [AW-1:0] A_PHI  = 12'h206;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr = 1'b0, rd = 1'b0, dbg = 1'b0, hit = 1'b0;
  logic [DW-1:0] rdata, cmp;
  logic          irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_mul_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .dbg_i(dbg), .rdata_o(rdata),
    .line_hit_i(hit), .cmp_o(cmp), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input bit dq, output logic [DW-1:0] d);
    @(negedge clk); addr = a; dbg = dq; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; dbg = 1'b0;
  endtask

  task automatic pulse_hit();
    @(negedge clk); hit = 1'b1;
    @(negedge clk); hit = 1'b0;
  endtask

  initial begin
    #700000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, plo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 cmp", cmp, 0);
    rd_reg(A_STAT, 1, v); check("R1 status", v, 8'h00);
    rd_reg(A_PLO, 1, v);  check("R1 prod lo", v, 8'h00);
    rd_reg(A_PHI, 1, v);  check("R1 prod hi", v, 8'h00);

    // R2 target scanline
    wr_reg(A_CMP, 8'hA7); check("R2 cmp", cmp, 8'hA7);
    wr_reg(A_CMP, 8'h3C); check("R2 cmp reload", cmp, 8'h3C);

    // R3 only bit 7 enables
    wr_reg(A_STAT, 8'h7F);
    pulse_hit();
    check("R3 low bits no enable", irq, 0);
    rd_reg(A_STAT, 1, v); check("R4 status after hit", v, 8'h80);

    // R5 gating
    wr_reg(A_STAT, 8'h80); check("R5 irq on", irq, 1);
    wr_reg(A_STAT, 8'h00); check("R5 irq off by enable", irq, 0);
    rd_reg(A_STAT, 1, v);  check("R5 flag kept", v, 8'h80);
    wr_reg(A_STAT, 8'hFF); check("R5 irq back", irq, 1);

    // R7 debug read has no effect; open bus still holds 0xFF
    rd_reg(A_STAT, 1, v); check("R7 dbg data", v, 8'h80);
    check("R7 irq kept", irq, 1);
    rd_reg(A_STAT, 1, v); check("R7 flag kept", v, 8'h80);
    rd_reg(12'h100, 0, v); check("R7 open bus untouched", v, 8'hFF);

    // R6 acknowledging read
    rd_reg(A_STAT, 0, v); check("R6 read data", v, 8'h80);
    check("R6 irq dropped", irq, 0);
    rd_reg(A_STAT, 1, v); check("R6 flag cleared", v, 8'h00);
    rd_reg(12'h7FF, 0, v); check("R9 bus after status read", v, 8'h80);

    // R10 match and acknowledge in one cycle
    pulse_hit();
    check("R5 irq from new hit", irq, 1);
    @(negedge clk); addr = A_STAT; rd = 1'b1; hit = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; hit = 1'b0;
    check("R10 old status", v, 8'h80);
    check("R10 irq held", irq, 1);
    rd_reg(A_STAT, 1, v); check("R10 flag set", v, 8'h80);

    // R9 open bus
    wr_reg(A_PLO, 8'h5A);
    rd_reg(12'h000, 0, v); check("R9 last write", v, 8'h5A);
    rd_reg(A_CMP, 0, v);   check("R9 cmp offset unmapped", v, 8'h5A);
    wr_reg(A_PHI, 8'h03);
    rd_reg(A_PLO, 0, plo); check("R8 lo", plo, 8'h0E);
    rd_reg(12'hFFF, 0, v); check("R9 last read", v, plo);

    // R8 sweep
    for (int b = 0; b < 256; b += 17) begin
      wr_reg(A_PHI, DW'(b));
      for (int a = 0; a < 256; a++) begin
        logic [15:0] p;
        p = 16'(a) * 16'(b);
        wr_reg(A_PLO, DW'(a));
        rd_reg(A_PLO, 0, v); check("R8 product lo", v, p[7:0]);
        rd_reg(A_PHI, 1, v); check("R8 product hi", v, p[15:8]);
      end
    end
    wr_reg(A_PLO, 8'hFF); wr_reg(A_PHI, 8'hFF);
    rd_reg(A_PHI, 0, v); check("R8 max hi", v, 8'hFE);
    rd_reg(A_PLO, 0, v); check("R8 max lo", v, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule